// File: doc/BRIEF.md
# Vector Mask Compress and Expand Unit

This unit rearranges the elements of a vector under a mask that carries one bit per element. In compress mode it gathers the elements whose mask bit is set and packs them in ascending order at the low end of the destination, starting at element 0. It also reports how many elements were packed, which can then serve as the new vector length. Expand mode reverses this. Consecutive source elements, starting at element 0, are placed into the destination positions whose mask bit is set. Destination positions whose mask bit is clear keep the value they already hold.

The unit handles one element per cycle. It walks the element index from 0 up to the effective vector length minus one. A running pointer moves forward only on set mask bits. In compress mode the pointer is the write address, and in expand mode it is the read address. Operands reach the unit through a streaming port pair on a register file model: a read address with combinational read data coming back, and a write strobe with its address and data. A start pulse launches an operation. The unit holds busy while it steps through the elements and gives a single done pulse when it finishes.

Top module: `vector_cx_unit`

## Requirements
- R1: In compress mode (mode_i = 0), the k-th element, counted from 0, whose mask bit is set is written to destination element k. The order is ascending source index.
- R2: count_o equals the number of set mask bits below the effective length. It is valid when done_o is high and stays unchanged until the next accepted start.
- R3: In expand mode (mode_i = 1), source element k is written to the position of the k-th set mask bit.
- R4: In expand mode, every destination element whose mask bit is clear, or whose index is at or above the effective length, keeps its previous value.
- R5: In compress mode, every destination element at or above count_o keeps its previous value.
- R6: The effective length is vl_i, clamped to NUM_ELEM. Mask bits at positions at or above the effective length have no effect.
- R7: busy_o is high during exactly one cycle per element. done_o is a single-cycle pulse that appears effective-length + 1 cycles after the clock edge that accepts start_i. busy_o and done_o are never high together, and a write happens only while busy_o is high.
- R8: start_i is accepted only when busy_o and done_o are both low. A start pulse raised during an operation has no effect on that operation.
- R9: An all-zero mask completes with count_o = 0 and no writes. A zero effective length completes one cycle after the start edge with no writes.
- R10: After reset, busy_o, done_o and wr_en_o are low and count_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launches an operation when the unit is idle |
| mode_i | input | 1 | 0 = compress, 1 = expand; sampled with start_i |
| mask_i | input | NUM_ELEM | Element mask; sampled with start_i |
| vl_i | input | CNT_W | Requested vector length; sampled with start_i |
| busy_o | output | 1 | High during the element-processing cycles |
| done_o | output | 1 | One-cycle completion pulse |
| count_o | output | CNT_W | Number of set mask bits within the effective length |
| rd_addr_o | output | IDX_W | Source element index for the register file read |
| rd_data_i | input | ELEM_W | Source element value returned combinationally |
| wr_en_o | output | 1 | Destination write strobe |
| wr_addr_o | output | IDX_W | Destination element index |
| wr_data_o | output | ELEM_W | Destination element value |

## Verification
The bench builds the unit with NUM_ELEM = 8 and ELEM_W = 16, so CNT_W is 4. A 4-bit vl_i can therefore carry values from 9 to 15, and the bench uses one of them to exercise the clamp. With only eight elements, a full mask, an empty mask, masks that set bits only at the low end or the high end, and masks with bits above a short length can all be checked against the complete destination contents. The bench also measures the latency cycle by cycle against the expected effective length.

// File: rtl/vcx_pkg.sv
package vcx_pkg;

    typedef enum logic {
        VCX_COMPRESS = 1'b0,
        VCX_EXPAND   = 1'b1
    } vcx_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } vcx_state_e;

    // Per-cycle step descriptor handed from sequencer to router
    typedef struct packed {
        logic      active;
        logic      hit;
        vcx_mode_e mode;
    } vcx_step_t;

endpackage

// File: rtl/vcx_seq.sv
module vcx_seq
    import vcx_pkg::*;
#(
    parameter int NUM_ELEM = 8,
    parameter int IDX_W    = 3,
    parameter int CNT_W    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                mode_i,
    input  logic [NUM_ELEM-1:0] mask_i,
    input  logic [CNT_W-1:0]    vl_i,
    output vcx_step_t           step_o,
    output logic [IDX_W-1:0]    idx_o,
    output logic                launch_o,
    output logic                busy_o,
    output logic                done_o
);

    localparam logic [CNT_W-1:0] VL_MAX = CNT_W'(NUM_ELEM);

    vcx_state_e          state_q;
    vcx_mode_e           mode_q;
    logic [NUM_ELEM-1:0] mask_q;
    logic [CNT_W-1:0]    vl_q;
    logic [IDX_W-1:0]    idx_q;
    logic [CNT_W-1:0]    vl_eff;
    logic                last_elem;

    assign vl_eff    = (vl_i > VL_MAX) ? VL_MAX : vl_i;
    assign launch_o  = start_i && (state_q == ST_IDLE);
    assign last_elem = ((CNT_W'(idx_q) + 1'b1) == vl_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= VCX_COMPRESS;
            mask_q  <= '0;
            vl_q    <= '0;
            idx_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        mode_q  <= vcx_mode_e'(mode_i);
                        mask_q  <= mask_i;
                        vl_q    <= vl_eff;
                        idx_q   <= '0;
                        state_q <= (vl_eff == '0) ? ST_FIN : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (last_elem) state_q <= ST_FIN;
                    else           idx_q   <= idx_q + 1'b1;
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign step_o.active = (state_q == ST_RUN);
    assign step_o.hit    = mask_q[idx_q];
    assign step_o.mode   = mode_q;
    assign idx_o         = idx_q;
    assign busy_o        = (state_q == ST_RUN);
    assign done_o        = (state_q == ST_FIN);

endmodule

// File: rtl/vcx_route.sv
module vcx_route
    import vcx_pkg::*;
#(
    parameter int ELEM_W = 16,
    parameter int IDX_W  = 3,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch_i,
    input  vcx_step_t         step_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [ELEM_W-1:0] rd_data_i,
    output logic [IDX_W-1:0]  rd_addr_o,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_addr_o,
    output logic [ELEM_W-1:0] wr_data_o,
    output logic [CNT_W-1:0]  count_o
);

    // Running population count of mask bits seen so far
    logic [CNT_W-1:0] ptr_q;
    logic [IDX_W-1:0] ptr_idx;

    assign ptr_idx = ptr_q[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst)                              ptr_q <= '0;
        else if (launch_i)                    ptr_q <= '0;
        else if (step_i.active && step_i.hit) ptr_q <= ptr_q + 1'b1;
    end

    always_comb begin
        wr_en_o   = step_i.active && step_i.hit;
        wr_data_o = rd_data_i;
        if (step_i.mode == VCX_COMPRESS) begin
            rd_addr_o = idx_i;
            wr_addr_o = ptr_idx;
        end else begin
            rd_addr_o = ptr_idx;
            wr_addr_o = idx_i;
        end
    end

    assign count_o = ptr_q;

endmodule

// File: rtl/vector_cx_unit.sv
module vector_cx_unit
    import vcx_pkg::*;
#(
    parameter int NUM_ELEM = 8,
    parameter int ELEM_W   = 16,
    localparam int IDX_W   = $clog2(NUM_ELEM),
    localparam int CNT_W   = $clog2(NUM_ELEM + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                mode_i,
    input  logic [NUM_ELEM-1:0] mask_i,
    input  logic [CNT_W-1:0]    vl_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [CNT_W-1:0]    count_o,
    output logic [IDX_W-1:0]    rd_addr_o,
    input  logic [ELEM_W-1:0]   rd_data_i,
    output logic                wr_en_o,
    output logic [IDX_W-1:0]    wr_addr_o,
    output logic [ELEM_W-1:0]   wr_data_o
);

    vcx_step_t        step;
    logic [IDX_W-1:0] idx;
    logic             launch;

    vcx_seq #(
        .NUM_ELEM (NUM_ELEM),
        .IDX_W    (IDX_W),
        .CNT_W    (CNT_W)
    ) seq_i (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .mode_i   (mode_i),
        .mask_i   (mask_i),
        .vl_i     (vl_i),
        .step_o   (step),
        .idx_o    (idx),
        .launch_o (launch),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    vcx_route #(
        .ELEM_W (ELEM_W),
        .IDX_W  (IDX_W),
        .CNT_W  (CNT_W)
    ) route_i (
        .clk       (clk),
        .rst       (rst),
        .launch_i  (launch),
        .step_i    (step),
        .idx_i     (idx),
        .rd_data_i (rd_data_i),
        .rd_addr_o (rd_addr_o),
        .wr_en_o   (wr_en_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o),
        .count_o   (count_o)
    );

endmodule

// File: rtl/vcx_chk.sv
module vcx_chk #(
    parameter int IDX_W = 3,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             mode_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             wr_en_o,
    input logic [IDX_W-1:0] wr_addr_o,
    input logic [CNT_W-1:0] count_o
);

    logic             mode_r;
    logic             seen_q;
    logic [IDX_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_r <= 1'b0;
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (start_i && !busy_o && !done_o) begin
            mode_r <= mode_i;
            seen_q <= 1'b0;
        end else if (wr_en_o) begin
            seen_q <= 1'b1;
            last_q <= wr_addr_o;
        end
    end

    p_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));

    p_wr_busy_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> busy_o);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_busy_start_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> (busy_o || done_o));

    p_first_pack_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o && !mode_r && !seen_q) |-> (wr_addr_o == '0));

    p_next_pack_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o && !mode_r && seen_q) |-> (wr_addr_o == last_q + 1'b1));

    p_scatter_up_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o && mode_r && seen_q) |-> (wr_addr_o > last_q));

    p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(count_o));

endmodule

bind vector_cx_unit vcx_chk #(
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .mode_i    (mode_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .count_o   (count_o)
);

// File: tb/vector_cx_unit_tb_top.sv
`timescale 1ns/1ps
module vector_cx_unit_tb_top;

    localparam int NE = 8;
    localparam int EW = 16;
    localparam int IW = 3;
    localparam int CW = 4;
    localparam int NT = 10;

    localparam logic          T_MODE [NT] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1,
                                              1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
    localparam logic [NE-1:0] T_MASK [NT] = '{8'b1011_0010, 8'hFF, 8'hFF, 8'b1011_0010, 8'h0F,
                                              8'hF0, 8'h81, 8'hFF, 8'h00, 8'hAA};
    localparam logic [CW-1:0] T_VL   [NT] = '{4'd8, 4'd8, 4'd5, 4'd8, 4'd8,
                                              4'd6, 4'd8, 4'd3, 4'd8, 4'd12};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          mode_i = 1'b0;
    logic [NE-1:0] mask_i = '0;
    logic [CW-1:0] vl_i = '0;
    logic          busy_o, done_o, wr_en_o;
    logic [CW-1:0] count_o;
    logic [IW-1:0] rd_addr_o, wr_addr_o;
    logic [EW-1:0] rd_data_i, wr_data_o;

    logic [EW-1:0] src [NE];
    logic [EW-1:0] dst [NE];
    logic [EW-1:0] expd [NE];
    logic          load_req = 1'b0;
    int            wr_total = 0;
    int            n_chk = 0;
    int            n_fail = 0;

    always #2.5 clk = ~clk;

    vector_cx_unit #(.NUM_ELEM(NE), .ELEM_W(EW)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
        .mask_i(mask_i), .vl_i(vl_i), .busy_o(busy_o), .done_o(done_o),
        .count_o(count_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
        .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
    );

    // Register file model: combinational read of src, clocked write of dst
    assign rd_data_i = src[rd_addr_o];

    function automatic logic [EW-1:0] dinit(int i);
        return 16'hD000 + 16'(i * 16'h11);
    endfunction

    always @(posedge clk) begin
        if (load_req) begin
            for (int i = 0; i < NE; i++) dst[i] <= dinit(i);
        end else if (wr_en_o) begin
            dst[wr_addr_o] <= wr_data_o;
            wr_total <= wr_total + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_case(input int id, input logic m, input logic [NE-1:0] msk,
                            input logic [CW-1:0] vl, input bit poke);
        int vle, k, lat, w0;
        vle = (int'(vl) > NE) ? NE : int'(vl);
        for (int i = 0; i < NE; i++) src[i] = 16'(16'h100 * (id + 1) + i);
        @(negedge clk) load_req = 1'b1;
        @(negedge clk) load_req = 1'b0;
        for (int i = 0; i < NE; i++) expd[i] = dinit(i);
        k = 0;
        for (int i = 0; i < vle; i++) begin
            if (msk[i]) begin
                if (m == 1'b0) expd[k] = src[i];
                else           expd[i] = src[k];
                k++;
            end
        end
        w0 = wr_total;
        start_i = 1'b1; mode_i = m; mask_i = msk; vl_i = vl;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 40) begin
            if (poke && lat == 2) begin
                start_i = 1'b1; mode_i = ~m; mask_i = ~msk; vl_i = 4'd8;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start_i = 1'b0;
        chk(lat == vle + 1, "R7 latency", lat, vle + 1);
        chk(int'(count_o) == k, "R2 count", int'(count_o), k);
        chk(wr_total - w0 == k, (k == 0) ? "R9 write total" : "R6 write total", wr_total - w0, k);
        for (int i = 0; i < NE; i++) begin
            string tg;
            if (m == 1'b0) tg = (i < k) ? "R1 packed" : "R5 untouched";
            else           tg = (i < vle && msk[i]) ? "R3 scattered" : "R4 kept";
            chk(dst[i] == expd[i], tg, int'(dst[i]), int'(expd[i]));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int c0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(busy_o == 1'b0, "R10 busy", int'(busy_o), 0);
        chk(done_o == 1'b0, "R10 done", int'(done_o), 0);
        chk(wr_en_o == 1'b0, "R10 wr_en", int'(wr_en_o), 0);
        chk(count_o == '0, "R10 count", int'(count_o), 0);
        rst = 1'b0;
        @(negedge clk);

        for (int t = 0; t < NT; t++) run_case(t, T_MODE[t], T_MASK[t], T_VL[t], 1'b0);

        // R9 zero effective length
        run_case(20, 1'b0, 8'hFF, 4'd0, 1'b0);
        run_case(21, 1'b1, 8'hFF, 4'd0, 1'b0);

        // R8 start pulses during a run are ignored
        run_case(22, 1'b0, 8'b0110_1001, 4'd8, 1'b1);
        run_case(23, 1'b1, 8'b0011_0101, 4'd7, 1'b1);

        // R2 count held after completion
        c0 = int'(count_o);
        repeat (4) @(negedge clk);
        chk(int'(count_o) == c0, "R2 hold", int'(count_o), c0);
        chk(busy_o == 1'b0 && wr_en_o == 1'b0, "R7 idle after done", int'(busy_o), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule